// File: doc/BRIEF.md
# Match-Compare Watchdog

This block guards against a stalled program by counting the overflow pulses of a free-running interval timer. The number of pulses seen since the last restart is compared with a programmable limit. When the count equals the limit, the block takes action. In reset mode it emits a reset pulse. In interrupt mode it emits an interrupt pulse. In both cases the count then starts again from zero. Software keeps the watchdog quiet by issuing a clear strobe before the limit is reached.

The limit register shares one write address with the reload register of a neighbouring watch timer. A select line that goes with each write decides which of the two registers the data lands in, and the other register keeps its value. A separate mode write chooses between reset and interrupt action. Reset action is active from reset onwards, so an unserviced watchdog resets the chip without any setup. The interval timer that produces the pulses is outside the block.

Top module: `wdog_match`

## Requirements
- R1: After reset both `wd_irq` and `wd_rst` are low, `wd_limit` reads 8'hFF, `wt_reload` reads 8'h00 and reset mode is selected, so 256 pulses with no clear give a `wd_rst` pulse.
- R2: The count rises by one on each cycle where `ovf_tick` is high. A match happens on the tick that finds the count equal to the limit N, which is the (N+1)th tick after the count was cleared.
- R3: In reset mode (the last `mode_we` wrote `mode_reset`=1, or no mode write since reset), a match drives `wd_rst` high for exactly the cycle after the matching tick, and `wd_irq` stays low.
- R4: In interrupt mode (`mode_reset`=0 written), a match drives `wd_irq` high for exactly the cycle after the matching tick, and `wd_rst` stays low.
- R5: A match clears the count, so without a clear the next match comes another N+1 ticks later.
- R6: A `kick` clears the count to zero, so the next match comes N+1 ticks after the kick.
- R7: When `kick` and a matching tick fall in the same cycle, the kick wins: neither output pulses and the count restarts from zero.
- R8: A write with `bus_we`=1 updates `wd_limit` when `bus_sel_wd`=1 and `wt_reload` when `bus_sel_wd`=0. The register that is not selected is unchanged.
- R9: `wd_irq` and `wd_rst` are never high in the same cycle.
- R10: In cycles without `ovf_tick`, the count holds and no output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_tick | input | 1 | One-cycle overflow pulse from the interval timer |
| kick | input | 1 | Clear strobe from software; restarts the count |
| bus_we | input | 1 | Write strobe for the shared register address |
| bus_sel_wd | input | 1 | Load select: 1 writes the watchdog limit, 0 writes the watch-timer reload |
| bus_wdata | input | W | Write data |
| mode_we | input | 1 | Write strobe for the action mode |
| mode_reset | input | 1 | Mode value: 1 = reset on match, 0 = interrupt on match |
| wd_irq | output | 1 | Interrupt pulse on a match in interrupt mode |
| wd_rst | output | 1 | Reset pulse on a match in reset mode |
| wd_limit | output | W | Current watchdog limit |
| wt_reload | output | W | Current watch-timer reload value |

## Verification
The two events that can fall in the same cycle are a software clear and a matching tick. The bench provokes this by driving `kick` together with the tick that would match. It judges the outcome by checking that no pulse appears in the following cycle and that a full N+1 further ticks are needed before the next match. The same collision is also covered by a property that forbids any output pulse in the cycle after a kick.

// File: rtl/wdog_match.sv
module wdog_match #(
  parameter int W = 8,
  parameter logic [W-1:0] LIMIT_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ovf_tick,
  input  logic         kick,
  input  logic         bus_we,
  input  logic         bus_sel_wd,
  input  logic [W-1:0] bus_wdata,
  input  logic         mode_we,
  input  logic         mode_reset,
  output logic         wd_irq,
  output logic         wd_rst,
  output logic [W-1:0] wd_limit,
  output logic [W-1:0] wt_reload
);

  logic [W-1:0] cnt;
  logic         rst_mode;
  logic         hit;
  logic         fire;

  assign hit  = ovf_tick && (cnt == wd_limit);
  assign fire = hit && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      wd_limit  <= LIMIT_INIT;
      wt_reload <= '0;
      rst_mode  <= 1'b1;
      wd_irq    <= 1'b0;
      wd_rst    <= 1'b0;
    end else begin
      if (kick || hit)   cnt <= '0;
      else if (ovf_tick) cnt <= cnt + W'(1);
      if (bus_we && bus_sel_wd)  wd_limit  <= bus_wdata;
      if (bus_we && !bus_sel_wd) wt_reload <= bus_wdata;
      if (mode_we) rst_mode <= mode_reset;
      wd_irq <= fire && !rst_mode;
      wd_rst <= fire && rst_mode;
    end
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_irq && wd_rst));

  assert_kick_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!wd_irq && !wd_rst && cnt == '0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_tick && !kick) |=> ($stable(cnt) && !wd_irq && !wd_rst));

  assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> $past(ovf_tick && !kick));

  assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_irq) |-> $past(ovf_tick && !kick));

  assert_route_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_sel_wd) |=> $stable(wd_limit));

  assert_route_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel_wd) |=> $stable(wt_reload));

endmodule

// File: tb/test_wdog_match.sv
module test_wdog_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovf_tick = 1'b0, kick = 1'b0, bus_we = 1'b0, bus_sel_wd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       mode_we = 1'b0, mode_reset = 1'b0;
  logic       wd_irq, wd_rst;
  logic [7:0] wd_limit, wt_reload;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  wdog_match i_wdog_match (
    .clk(clk), .rst_n(rst_n), .ovf_tick(ovf_tick), .kick(kick),
    .bus_we(bus_we), .bus_sel_wd(bus_sel_wd), .bus_wdata(bus_wdata),
    .mode_we(mode_we), .mode_reset(mode_reset),
    .wd_irq(wd_irq), .wd_rst(wd_rst), .wd_limit(wd_limit), .wt_reload(wt_reload)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input bit ei, input bit er);
    chk(req, {wd_irq, wd_rst}, {ei, er});
  endtask

  // one tick (optionally with kick), then gap idle cycles; outputs checked after each
  task automatic tick(input int gap, input bit k, input bit ei, input bit er, input string req);
    ovf_tick = 1'b1; kick = k;
    @(negedge clk);
    ovf_tick = 1'b0; kick = 1'b0;
    outs(req, ei, er);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      outs("R10", 1'b0, 1'b0);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    bus_we = 1'b1; bus_sel_wd = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_mode(input bit m);
    mode_we = 1'b1; mode_reset = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    outs("R6", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    outs("R1", 1'b0, 1'b0);
    chk("R1", wd_limit, 8'hFF);
    chk("R1", wt_reload, 8'h00);
    // R1/R3: default reset mode, limit FF -> 256th tick fires reset
    for (int t = 1; t <= 256; t++)
      tick(0, 1'b0, 1'b0, t == 256, "R1");
    @(negedge clk);
    outs("R3", 1'b0, 1'b0);

    // R8: routing by select
    wr(1'b0, 8'h5A);
    chk("R8", wt_reload, 8'h5A);
    chk("R8", wd_limit, 8'hFF);
    wr(1'b1, 8'h03);
    chk("R8", wd_limit, 8'h03);
    chk("R8", wt_reload, 8'h5A);

    // R2/R3/R4/R5/R10 sweep over mode, limit, tick spacing
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 7; n++)
        for (int gap = 0; gap < 3; gap++) begin
          set_mode(m[0]);
          wr(1'b1, 8'(n));
          do_kick();
          for (int t = 1; t <= n + 1; t++)
            tick(gap, 1'b0, (t == n + 1) && m == 0, (t == n + 1) && m == 1,
                 m == 1 ? "R3" : "R4");
          for (int t = 1; t <= n + 1; t++)
            tick(gap, 1'b0, (t == n + 1) && m == 0, (t == n + 1) && m == 1, "R5");
          @(negedge clk);
          outs("R2", 1'b0, 1'b0);
        end

    // R7: kick on the matching tick
    set_mode(1'b0);
    wr(1'b1, 8'd2);
    do_kick();
    tick(0, 1'b0, 1'b0, 1'b0, "R7");
    tick(0, 1'b0, 1'b0, 1'b0, "R7");
    tick(1, 1'b1, 1'b0, 1'b0, "R7");
    tick(0, 1'b0, 1'b0, 1'b0, "R7");
    tick(0, 1'b0, 1'b0, 1'b0, "R7");
    tick(0, 1'b0, 1'b1, 1'b0, "R7");

    // R6: kick mid-count restarts
    wr(1'b1, 8'd4);
    do_kick();
    for (int t = 1; t <= 3; t++) tick(0, 1'b0, 1'b0, 1'b0, "R6");
    do_kick();
    for (int t = 1; t <= 5; t++) tick(0, 1'b0, t == 5, 1'b0, "R6");

    // R9: reset mode after interrupt mode, idle hold with long gap
    set_mode(1'b1);
    do_kick();
    for (int t = 1; t <= 5; t++) tick(6, 1'b0, 1'b0, t == 5, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule